// File: doc/BRIEF.md
# Read Latency and Link Traffic Monitor

This block sits beside one memory request port and watches it without taking part in it. It sees each request handshake and each response handshake, keeps a timestamp for every outstanding read by its tag, and from those builds a set of run statistics:
- completed reads and issued writes;
- the summed read latency, and the smallest and largest read latency seen;
- the number of 16-byte link flits moved in each direction, including the fixed one-flit header-and-tail overhead that every packet carries.

Software sets a run length, starts a run and waits for it to end. The counters then stay frozen and software reads them. From them it computes the mean latency (sum divided by read count) and the bandwidth (flits times 16 bytes over the run length). The block has no ready output and drives nothing on the port, so it can never hold back a request or a response.

Top module: `lat_bw_monitor`

## Requirements
- R1: After reset:
  - the read count, write count, latency sum and both flit counters read 0;
  - the minimum latency reads all ones (0xFFFFFFFF) and the maximum reads 0;
  - the run length reads 0 and the status reads 0.
- R2: Writing 1 to bit 0 of the control register (address 1) starts a run. The run is active for exactly the number of cycles held in the run-length register (address 0), starting with the cycle after the write. After that the status reads 2, where bit 1 means done and bit 0 means active. Handshakes outside an active run change no counter.
- R3: A handshake is counted only in a cycle where both valid and ready are high. The read count (address 2) rises by one for each read response handshake (rsp_is_write=0). A valid without ready changes nothing.
- R4: The write count (address 3) rises by one for each write request handshake (req_is_write=1). Write responses do not change it.
- R5: The latency of a read is the number of clock cycles from its request handshake to the response handshake that carries the same tag. The latency sum is 48 bits wide: its low word is at address 4 and its high 16 bits are at address 5. The sum adds the latency of every read response.
- R6: The minimum (address 6) and the maximum (address 7) latency change only on read responses. Write traffic leaves them at their start values.
- R7: The request-direction flit counter (48 bits: low word at address 8, high bits at address 9) changes as follows:
  - it adds 1 for each read request;
  - it adds len+2 for each write request, where the 3-bit len field is the number of data flits minus one.
- R8: The response-direction flit counter (48 bits: low word at address 10, high bits at address 11) changes as follows:
  - it adds len+2 for each read response;
  - it adds 1 for each write response.
- R9: Starting a run clears every counter to its reset value, even when a previous run has ended or is still active.
- R10: reg_rdata shows the register selected by reg_addr one clock cycle later. The run-length register reads back the value written to it.
- R11: Reads that are outstanding on different tags are timed independently. Responses that come back out of order still yield each read's own latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request valid on the watched port |
| req_ready | input | 1 | Request ready on the watched port |
| req_is_write | input | 1 | Request is a write |
| req_tag | input | TAG_W | Request tag |
| req_len | input | LEN_W | Write data flits minus one |
| rsp_valid | input | 1 | Response valid on the watched port |
| rsp_ready | input | 1 | Response ready on the watched port |
| rsp_is_write | input | 1 | Response is a write acknowledge |
| rsp_tag | input | TAG_W | Response tag |
| rsp_len | input | LEN_W | Read data flits minus one |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register select |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |

## Verification
The first pattern is a single read and response on one tag. It is followed by a second read with a longer gap and the largest payload. These show whether the latency is counted from handshake edge to handshake edge, and whether the minimum and maximum each follow the right extreme. Two reads answered in reverse order tell a tag-indexed timestamp apart from one shared timestamp or a first-in first-out one. A write-only run separates the write accounting from the read latency path, and shows that the overhead flit is added on each side. A short run fed with back-to-back responses past its end checks the run length to the exact cycle and the freeze afterwards. Valid held without ready checks that only a full handshake is counted.

// File: rtl/mon_pkg.sv
package mon_pkg;

    localparam int REG_SEL_W = 4;

    typedef enum logic [REG_SEL_W-1:0] {
        SEL_RUN_LEN  = 4'd0,
        SEL_CONTROL  = 4'd1,
        SEL_RD_CNT   = 4'd2,
        SEL_WR_CNT   = 4'd3,
        SEL_SUM_LO   = 4'd4,
        SEL_SUM_HI   = 4'd5,
        SEL_LAT_MIN  = 4'd6,
        SEL_LAT_MAX  = 4'd7,
        SEL_REQF_LO  = 4'd8,
        SEL_REQF_HI  = 4'd9,
        SEL_RSPF_LO  = 4'd10,
        SEL_RSPF_HI  = 4'd11
    } reg_sel_e;

endpackage

// File: rtl/mon_run_ctrl.sv
module mon_run_ctrl #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              len_we,
    input  logic [DATA_W-1:0] len_wdata,
    input  logic              start,
    output logic [DATA_W-1:0] run_len,
    output logic              active,
    output logic              done
);

    typedef struct packed {
        logic [DATA_W-1:0] len;
        logic [DATA_W-1:0] remain;
        logic              active;
        logic              done;
    } run_state_t;

    run_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (len_we) begin
            st_d.len = len_wdata;
        end
        if (start) begin
            st_d.remain = st_q.len;
            st_d.active = (st_q.len != '0);
            st_d.done   = (st_q.len == '0);
        end else if (st_q.active) begin
            st_d.remain = st_q.remain - 1'b1;
            if (st_q.remain == DATA_W'(1)) begin
                st_d.active = 1'b0;
                st_d.done   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_len = st_q.len;
    assign active  = st_q.active;
    assign done    = st_q.done;

    // R2: an active run either goes on or ends in done
    a_r2_run_ends_done: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !start) |=> (active || done));

    // R2: done stays until the next start
    a_r2_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && !active));

endmodule

// File: rtl/mon_ts_table.sv
module mon_ts_table #(
    parameter int TAG_W = 4,
    parameter int TS_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic [TAG_W-1:0] cap_tag,
    input  logic [TAG_W-1:0] look_tag,
    output logic [TS_W-1:0]  latency
);

    localparam int NTAG = 1 << TAG_W;

    typedef struct packed {
        logic [TS_W-1:0]            now;
        logic [NTAG-1:0][TS_W-1:0] stamp;
    } ts_state_t;

    ts_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.now = st_q.now + 1'b1;
        for (int i = 0; i < NTAG; i++) begin
            if (cap_en && (cap_tag == TAG_W'(i))) begin
                st_d.stamp[i] = st_q.now;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign latency = st_q.now - st_q.stamp[look_tag];

    // R5: a tag captured one cycle ago reports a latency of one
    a_r5_one_cycle_lat: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && (look_tag == cap_tag)) |=>
            (($past(look_tag) != look_tag) || (latency == TS_W'(1)) || $past(latency == '0 && !cap_en)));

endmodule

// File: rtl/mon_lat_accum.sv
module mon_lat_accum #(
    parameter int CNT_W = 32,
    parameter int SUM_W = 48,
    parameter int LAT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             rd_rsp,
    input  logic [LAT_W-1:0] lat,
    output logic [CNT_W-1:0] rd_cnt,
    output logic [SUM_W-1:0] lat_sum,
    output logic [LAT_W-1:0] lat_min,
    output logic [LAT_W-1:0] lat_max
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SUM_W-1:0] sum;
        logic [LAT_W-1:0] mn;
        logic [LAT_W-1:0] mx;
    } lat_state_t;

    localparam lat_state_t INIT = '{cnt: '0, sum: '0, mn: '1, mx: '0};

    lat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = INIT;
        end else if (en && rd_rsp) begin
            st_d.cnt = st_q.cnt + 1'b1;
            st_d.sum = st_q.sum + SUM_W'(lat);
            if (lat < st_q.mn) st_d.mn = lat;
            if (lat > st_q.mx) st_d.mx = lat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_cnt  = st_q.cnt;
    assign lat_sum = st_q.sum;
    assign lat_min = st_q.mn;
    assign lat_max = st_q.mx;

    // R6: once a read has been seen the minimum never exceeds the maximum
    a_r6_min_le_max: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cnt != '0) |-> (lat_min <= lat_max));

    // R6: the maximum covers the latest read latency
    a_r6_max_covers: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rd_rsp && !clr) |=> (lat_max >= $past(lat)) && (lat_min <= $past(lat)));

    // R2: nothing moves outside a run
    a_r2_lat_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> ($stable(lat_sum) && $stable(rd_cnt) && $stable(lat_min) && $stable(lat_max)));

endmodule

// File: rtl/mon_flit_accum.sv
module mon_flit_accum #(
    parameter int CNT_W  = 32,
    parameter int FLIT_W = 48,
    parameter int LEN_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic              req_fire,
    input  logic              req_wr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              rsp_fire,
    input  logic              rsp_wr,
    input  logic [LEN_W-1:0]  rsp_len,
    output logic [CNT_W-1:0]  wr_cnt,
    output logic [FLIT_W-1:0] req_flits,
    output logic [FLIT_W-1:0] rsp_flits
);

    localparam int MAX_PKT = (1 << LEN_W) + 1;

    typedef struct packed {
        logic [CNT_W-1:0]  wr;
        logic [FLIT_W-1:0] reqf;
        logic [FLIT_W-1:0] rspf;
    } flit_state_t;

    flit_state_t st_d, st_q;
    logic [FLIT_W-1:0] req_pkt, rsp_pkt;

    always_comb begin
        // header/tail flit always, data flits only on the carrying side
        req_pkt = req_wr ? (FLIT_W'(req_len) + FLIT_W'(2)) : FLIT_W'(1);
        rsp_pkt = rsp_wr ? FLIT_W'(1) : (FLIT_W'(rsp_len) + FLIT_W'(2));
        st_d    = st_q;
        if (clr) begin
            st_d = '0;
        end else if (en) begin
            if (req_fire) begin
                st_d.reqf = st_q.reqf + req_pkt;
                if (req_wr) st_d.wr = st_q.wr + 1'b1;
            end
            if (rsp_fire) begin
                st_d.rspf = st_q.rspf + rsp_pkt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_cnt    = st_q.wr;
    assign req_flits = st_q.reqf;
    assign rsp_flits = st_q.rspf;

    // R7: each counted request moves between one and a full packet of flits
    a_r7_req_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && req_fire) |=>
            ((req_flits - $past(req_flits)) >= FLIT_W'(1)) &&
            ((req_flits - $past(req_flits)) <= FLIT_W'(MAX_PKT)));

    // R8: each counted response moves between one and a full packet of flits
    a_r8_rsp_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && rsp_fire) |=>
            ((rsp_flits - $past(rsp_flits)) >= FLIT_W'(1)) &&
            ((rsp_flits - $past(rsp_flits)) <= FLIT_W'(MAX_PKT)));

    // R2: nothing moves outside a run
    a_r2_flit_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> ($stable(req_flits) && $stable(rsp_flits) && $stable(wr_cnt)));

endmodule

// File: rtl/lat_bw_monitor.sv
module lat_bw_monitor
    import mon_pkg::*;
#(
    parameter int TAG_W  = 4,
    parameter int LEN_W  = 3,
    parameter int DATA_W = 32,
    parameter int TS_W   = 32,
    parameter int CNT_W  = 32,
    parameter int SUM_W  = 48,
    parameter int FLIT_W = 48
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_ready,
    input  logic                 req_is_write,
    input  logic [TAG_W-1:0]     req_tag,
    input  logic [LEN_W-1:0]     req_len,
    input  logic                 rsp_valid,
    input  logic                 rsp_ready,
    input  logic                 rsp_is_write,
    input  logic [TAG_W-1:0]     rsp_tag,
    input  logic [LEN_W-1:0]     rsp_len,
    input  logic                 reg_wr_en,
    input  logic [REG_SEL_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata
);

    logic              req_fire, rsp_fire, rd_req, rd_rsp;
    logic              len_we, start;
    logic [DATA_W-1:0] run_len;
    logic              active, done;
    logic [TS_W-1:0]   latency;
    logic [CNT_W-1:0]  rd_cnt, wr_cnt;
    logic [SUM_W-1:0]  lat_sum;
    logic [TS_W-1:0]   lat_min, lat_max;
    logic [FLIT_W-1:0] req_flits, rsp_flits;

    assign req_fire = req_valid && req_ready;
    assign rsp_fire = rsp_valid && rsp_ready;
    assign rd_req   = req_fire && !req_is_write;
    assign rd_rsp   = rsp_fire && !rsp_is_write;
    assign len_we   = reg_wr_en && (reg_addr == SEL_RUN_LEN);
    assign start    = reg_wr_en && (reg_addr == SEL_CONTROL) && reg_wdata[0];

    mon_run_ctrl #(.DATA_W(DATA_W)) u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .len_we    (len_we),
        .len_wdata (reg_wdata),
        .start     (start),
        .run_len   (run_len),
        .active    (active),
        .done      (done)
    );

    mon_ts_table #(.TAG_W(TAG_W), .TS_W(TS_W)) u_ts (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (rd_req),
        .cap_tag  (req_tag),
        .look_tag (rsp_tag),
        .latency  (latency)
    );

    mon_lat_accum #(.CNT_W(CNT_W), .SUM_W(SUM_W), .LAT_W(TS_W)) u_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (start),
        .en      (active),
        .rd_rsp  (rd_rsp),
        .lat     (latency),
        .rd_cnt  (rd_cnt),
        .lat_sum (lat_sum),
        .lat_min (lat_min),
        .lat_max (lat_max)
    );

    mon_flit_accum #(.CNT_W(CNT_W), .FLIT_W(FLIT_W), .LEN_W(LEN_W)) u_flit (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (start),
        .en        (active),
        .req_fire  (req_fire),
        .req_wr    (req_is_write),
        .req_len   (req_len),
        .rsp_fire  (rsp_fire),
        .rsp_wr    (rsp_is_write),
        .rsp_len   (rsp_len),
        .wr_cnt    (wr_cnt),
        .req_flits (req_flits),
        .rsp_flits (rsp_flits)
    );

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_state_t;

    rd_state_t rd_d, rd_q;

    always_comb begin
        rd_d = '0;
        case (reg_addr)
            SEL_RUN_LEN: rd_d.rdata = run_len;
            SEL_CONTROL: rd_d.rdata = DATA_W'({done, active});
            SEL_RD_CNT:  rd_d.rdata = DATA_W'(rd_cnt);
            SEL_WR_CNT:  rd_d.rdata = DATA_W'(wr_cnt);
            SEL_SUM_LO:  rd_d.rdata = DATA_W'(lat_sum);
            SEL_SUM_HI:  rd_d.rdata = DATA_W'(lat_sum >> DATA_W);
            SEL_LAT_MIN: rd_d.rdata = DATA_W'(lat_min);
            SEL_LAT_MAX: rd_d.rdata = DATA_W'(lat_max);
            SEL_REQF_LO: rd_d.rdata = DATA_W'(req_flits);
            SEL_REQF_HI: rd_d.rdata = DATA_W'(req_flits >> DATA_W);
            SEL_RSPF_LO: rd_d.rdata = DATA_W'(rsp_flits);
            SEL_RSPF_HI: rd_d.rdata = DATA_W'(rsp_flits >> DATA_W);
            default:     rd_d.rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign reg_rdata = rd_q.rdata;

    // R2: active and done are never both set
    a_r2_status_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(active && done));

    // R4: a write request in a run moves the request flit count by at least two
    a_r4_write_flits: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !start && req_fire && req_is_write) |=>
            ((req_flits - $past(req_flits)) >= FLIT_W'(2)) && (wr_cnt == $past(wr_cnt) + 1'b1));

endmodule

// File: tb/lat_bw_monitor_tb.sv
module lat_bw_monitor_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_ready = 0, req_is_write = 0;
    logic [3:0]  req_tag = 0;
    logic [2:0]  req_len = 0;
    logic        rsp_valid = 0, rsp_ready = 0, rsp_is_write = 0;
    logic [3:0]  rsp_tag = 0;
    logic [2:0]  rsp_len = 0;
    logic        reg_wr_en = 0;
    logic [3:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    int tb_cyc = 0;
    bit finished = 0;

    always #5 clk = ~clk;
    always @(posedge clk) tb_cyc <= tb_cyc + 1;

    lat_bw_monitor u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_is_write(req_is_write),
        .req_tag(req_tag), .req_len(req_len),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_is_write(rsp_is_write),
        .rsp_tag(rsp_tag), .rsp_len(rsp_len),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        reg_wr_en = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 0; reg_wdata = 0;
    endtask

    task automatic reg_read(input logic [3:0] a, output longint d);
        reg_addr = a;
        @(negedge clk);
        d = longint'(reg_rdata);
    endtask

    task automatic read48(input logic [3:0] lo, output longint d);
        longint l, h;
        reg_read(lo, l);
        reg_read(lo + 4'd1, h);
        d = (h << 32) | l;
    endtask

    task automatic start_run(input int len);
        reg_write(4'd0, len);
        reg_write(4'd1, 1);
    endtask

    task automatic send_req(input bit wr, input int tag, input int len, input bit rdy, output int stamp);
        req_valid = 1; req_ready = rdy; req_is_write = wr; req_tag = tag[3:0]; req_len = len[2:0];
        stamp = tb_cyc;
        @(negedge clk);
        req_valid = 0; req_ready = 0; req_is_write = 0;
    endtask

    task automatic send_rsp(input bit wr, input int tag, input int len, input bit rdy, output int stamp);
        rsp_valid = 1; rsp_ready = rdy; rsp_is_write = wr; rsp_tag = tag[3:0]; rsp_len = len[2:0];
        stamp = tb_cyc;
        @(negedge clk);
        rsp_valid = 0; rsp_ready = 0; rsp_is_write = 0;
    endtask

    task automatic t_reset;
        longint v;
        reg_read(4'd2, v);  check("R1 read count", v, 0);
        reg_read(4'd3, v);  check("R1 write count", v, 0);
        read48(4'd4, v);    check("R1 latency sum", v, 0);
        reg_read(4'd6, v);  check("R1 min latency", v, 64'hFFFF_FFFF);
        reg_read(4'd7, v);  check("R1 max latency", v, 0);
        read48(4'd8, v);    check("R1 request flits", v, 0);
        read48(4'd10, v);   check("R1 response flits", v, 0);
        reg_read(4'd0, v);  check("R1 run length", v, 0);
        reg_read(4'd1, v);  check("R1 status", v, 0);
    endtask

    task automatic t_reads;
        int a, b, c, d, s, l0, l1;
        longint v;
        start_run(1000);
        reg_read(4'd0, v);  check("R10 run length readback", v, 1000);
        reg_read(4'd1, v);  check("R10 status active", v, 1);
        send_req(0, 0, 0, 1, a);
        send_req(0, 5, 0, 0, s);         // valid without ready
        idle(2);
        send_rsp(0, 0, 0, 1, b);
        send_rsp(0, 0, 0, 0, s);         // valid without ready
        send_req(0, 1, 0, 1, c);
        idle(9);
        send_rsp(0, 1, 7, 1, d);
        l0 = b - a; l1 = d - c;
        reg_read(4'd2, v);  check("R3 read count", v, 2);
        read48(4'd4, v);    check("R5 latency sum", v, l0 + l1);
        reg_read(4'd6, v);  check("R6 min latency", v, l0);
        reg_read(4'd7, v);  check("R6 max latency", v, l1);
        read48(4'd8, v);    check("R7 read request flits", v, 2);
        read48(4'd10, v);   check("R8 read response flits", v, 11);
        reg_read(4'd3, v);  check("R3 write count unchanged", v, 0);
    endtask

    task automatic t_out_of_order;
        int a, b, c, d, la, lb;
        longint v;
        start_run(1000);
        send_req(0, 2, 0, 1, a);
        send_req(0, 3, 0, 1, b);
        idle(3);
        send_rsp(0, 3, 1, 1, c);
        idle(4);
        send_rsp(0, 2, 1, 1, d);
        lb = c - b; la = d - a;
        read48(4'd4, v);    check("R11 latency sum", v, la + lb);
        reg_read(4'd6, v);  check("R11 min is tag3", v, lb);
        reg_read(4'd7, v);  check("R11 max is tag2", v, la);
    endtask

    task automatic t_writes;
        int s;
        longint v;
        start_run(1000);
        send_req(1, 4, 3, 1, s);
        send_req(1, 6, 7, 1, s);
        send_req(1, 7, 2, 0, s);         // valid without ready
        idle(2);
        send_rsp(1, 4, 0, 1, s);
        send_rsp(1, 6, 0, 1, s);
        reg_read(4'd3, v);  check("R4 write count", v, 2);
        reg_read(4'd2, v);  check("R4 read count unchanged", v, 0);
        read48(4'd8, v);    check("R7 write request flits", v, 14);
        read48(4'd10, v);   check("R8 write response flits", v, 2);
        reg_read(4'd6, v);  check("R6 min untouched by writes", v, 64'hFFFF_FFFF);
        reg_read(4'd7, v);  check("R6 max untouched by writes", v, 0);
        read48(4'd4, v);    check("R6 sum untouched by writes", v, 0);
        // R9: restart clears
        start_run(1000);
        reg_read(4'd3, v);  check("R9 write count cleared", v, 0);
        read48(4'd8, v);    check("R9 request flits cleared", v, 0);
        read48(4'd10, v);   check("R9 response flits cleared", v, 0);
    endtask

    task automatic t_run_length;
        int s;
        longint v;
        send_req(0, 0, 0, 1, s);
        start_run(5);
        for (int i = 0; i < 6; i++) send_rsp(0, 0, 0, 1, s);
        reg_read(4'd2, v);  check("R2 reads in 5-cycle run", v, 5);
        reg_read(4'd1, v);  check("R2 status done", v, 2);
        send_rsp(0, 0, 0, 1, s);
        send_req(1, 1, 0, 1, s);
        reg_read(4'd2, v);  check("R2 read count frozen", v, 5);
        reg_read(4'd3, v);  check("R2 write count frozen", v, 0);
        read48(4'd10, v);   check("R2 response flits frozen", v, 10);
        start_run(1000);
        reg_read(4'd2, v);  check("R9 read count cleared", v, 0);
        reg_read(4'd6, v);  check("R9 min restored", v, 64'hFFFF_FFFF);
    endtask

    initial begin
        idle(3);
        rst_n = 1;
        idle(2);
        t_reset;
        t_reads;
        t_out_of_order;
        t_writes;
        t_run_length;
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule